// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog for a small processor subsystem. It counts bus-clock enables through a fixed power-of-two prescaler and then through a further divider. Software selects that divider as 1, 4, 16 or 64 with a two-bit rate field. If software does not service the watchdog before the divided count runs out, the block emits a one-cycle timeout pulse. A reset sequencer elsewhere turns that pulse into a system reset.

Servicing is a two-step keyed handshake on a small write port. First an arming byte is written to the service register, then a clearing byte. Unrelated writes may fall between the two steps. The rate field is writable at any time in special mode. In normal mode it takes a single write, and only during a short window after reset. The watchdog runs only while the configuration enable is set and the test/boot inhibit is clear.

Top module: `wdog_keyed`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rate_q` reads 2'b00 (the fastest setting) and `timeout` is low.
- R2: With `ce` held high and the watchdog running, timeout pulses are spaced exactly 2^PRE_BITS × D cycles apart. D is 1, 4, 16 or 64 for `rate_q` = 00, 01, 10 or 11.
- R3: In normal mode (`mode_special`=0), a write with `wr_sel`=0 loads `wr_data[1:0]` into the rate field only if it is the first such write since reset and falls within the first WIN_LEN `ce` cycles after reset. Every other rate write leaves `rate_q` unchanged.
- R4: In special mode (`mode_special`=1), every rate write loads `wr_data[1:0]` into `rate_q` on the next cycle.
- R5: Writing 8'h55 to the service register (`wr_sel`=1) arms it. A later write of 8'hAA restarts the divided count and disarms it. Writes of other values in between neither cancel nor complete the sequence.
- R6: An 8'hAA service write while not armed has no effect on the timeout schedule.
- R7: While `cfg_enable` is 0 or `inhibit` is 1, no timeout is produced. When running resumes, pulses return at the R2 spacing.
- R8: `timeout` is never high for two consecutive cycles.
- R9: Servicing does not reset the prescaler. After a completed service at rate 01, the next timeout comes more than 3 and no more than 4 prescaler periods (plus the output register) later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Bus-clock enable; one count per high cycle |
| cfg_enable | input | 1 | Configuration enable for the watchdog |
| inhibit | input | 1 | Test/boot disable bit; 1 holds the watchdog off |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = rate register, 1 = service register |
| wr_data | input | 8 | Write data byte |
| rate_q | output | 2 | Current rate-select field |
| timeout | output | 1 | One-cycle timeout pulse |

## Verification
The assertions assume that `rst` is asserted from time zero for at least one clock edge. They also assume that `ce` is a clean synchronous enable, so the prescaler advances by at most one per cycle. The stimulus meets this by raising reset before the first edge and driving every input on the falling clock edge, away from the sampling edge. Mode and enable inputs change only while the bench is between measurements, so each measured timeout spacing belongs to one configuration.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic       SEL_RATE = 1'b0;
  localparam logic       SEL_SVC  = 1'b1;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_CLR  = 8'hAA;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_BITS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic tick
);
  logic [PRE_BITS-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (ce) pre_q <= pre_q + 1'b1;
  end

  // free-running: a service never touches this counter
  assign tick = ce && (&pre_q);
endmodule

// File: rtl/wdog_svc_key.sv
module wdog_svc_key
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       svc_wr,
  input  logic [7:0] data,
  output logic       armed,
  output logic       clear
);
  assign clear = svc_wr && armed && (data == KEY_CLR);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (svc_wr && data == KEY_ARM) armed <= 1'b1;
    else if (clear) armed <= 1'b0;
  end
endmodule

// File: rtl/wdog_rate_ctl.sv
module wdog_rate_ctl #(
  parameter int RATE_W  = 2,
  parameter int WIN_LEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] data,
  input  logic              mode_special,
  output logic [RATE_W-1:0] rate,
  output logic              win_open
);
  localparam int WIN_W = $clog2(WIN_LEN + 1);

  logic [WIN_W-1:0] win_cnt_q;
  logic             used_q;
  logic             accept;

  assign win_open = (win_cnt_q < WIN_W'(WIN_LEN)) && !used_q;
  assign accept   = rate_wr && (mode_special || win_open);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt_q <= '0;
      used_q    <= 1'b0;
      rate      <= '0;
    end else begin
      if (ce && win_cnt_q < WIN_W'(WIN_LEN)) win_cnt_q <= win_cnt_q + 1'b1;
      if (accept) rate <= data;
      if (rate_wr && !mode_special) used_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int PRE_BITS = 15,
  parameter int RATE_W   = 2,
  parameter int STEP_LOG = 2,
  parameter int WIN_LEN  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              cfg_enable,
  input  logic              inhibit,
  input  logic              mode_special,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [7:0]        wr_data,
  output logic [RATE_W-1:0] rate_q,
  output logic              timeout
);
  localparam int CNT_W = STEP_LOG * ((1 << RATE_W) - 1);

  logic             tick;
  logic             armed;
  logic             svc_clear;
  logic             win_open;
  logic             active;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  wdog_prescale #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk(clk), .rst(rst), .ce(ce), .tick(tick)
  );

  wdog_svc_key u_key (
    .clk(clk), .rst(rst),
    .svc_wr(wr_en && wr_sel == SEL_SVC),
    .data(wr_data), .armed(armed), .clear(svc_clear)
  );

  wdog_rate_ctl #(.RATE_W(RATE_W), .WIN_LEN(WIN_LEN)) u_rate (
    .clk(clk), .rst(rst), .ce(ce),
    .rate_wr(wr_en && wr_sel == SEL_RATE),
    .data(wr_data[RATE_W-1:0]), .mode_special(mode_special),
    .rate(rate_q), .win_open(win_open)
  );

  assign active = cfg_enable && !inhibit;
  assign term   = ({{(CNT_W-1){1'b0}}, 1'b1} << (STEP_LOG * rate_q)) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!active || svc_clear) cnt_q <= '0;
      else if (tick) begin
        if (cnt_q >= term) begin
          cnt_q   <= '0;
          timeout <= 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int RATE_W = 2,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic              inhibit,
  input logic              mode_special,
  input logic              win_open,
  input logic              armed,
  input logic              svc_clear,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [RATE_W-1:0] rate_q,
  input logic              timeout
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (rate_q == '0 && !timeout)); // R1

  AST_LOCKED_RATE: assert property (@(posedge clk) disable iff (rst)
    (!mode_special && !win_open) |=> $stable(rate_q)); // R3

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    svc_clear |=> (!armed && cnt_q == '0 && !timeout)); // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable || inhibit) |=> !timeout); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout); // R8
endmodule

bind wdog_keyed wdog_keyed_chk #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .inhibit(inhibit),
  .mode_special(mode_special), .win_open(win_open), .armed(armed),
  .svc_clear(svc_clear), .cnt_q(cnt_q), .rate_q(rate_q), .timeout(timeout)
);

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;
  localparam int PRE_BITS = 3;
  localparam int PRE_P    = 1 << PRE_BITS;
  localparam int WIN_LEN  = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b1;
  logic       cfg_enable = 1'b1;
  logic       inhibit = 1'b0;
  logic       mode_special = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rate_q;
  logic       timeout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_keyed #(.PRE_BITS(PRE_BITS), .WIN_LEN(WIN_LEN)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .cfg_enable(cfg_enable),
    .inhibit(inhibit), .mode_special(mode_special), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rate_q(rate_q), .timeout(timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // wait for a timeout pulse, return cycles waited (-1 if none)
  task automatic wait_pulse(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (timeout) begin n = i; break; end
    end
  endtask

  task automatic period(output int p);
    int n;
    wait_pulse(2000, n);
    wait_pulse(2000, p);
  endtask

  task automatic count_pulses(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (timeout) n++;
    end
  endtask

  // two-cycle-high monitor for R8
  logic prev_to = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_to && timeout) check("R8", 1, 0);
    prev_to = timeout;
  end

  initial begin
    int p, n;
    // R1 reset state
    @(negedge clk);
    check("R1 rate", rate_q, 0);
    check("R1 timeout", timeout, 0);
    @(negedge clk); rst = 1'b0;
    check("R1 rate after release", rate_q, 0);

    // R2 + R4: sweep every rate in special mode
    for (int r = 0; r < 4; r++) begin
      wr(1'b0, 8'(r));
      check("R4 special write", rate_q, r);
      period(p);
      check("R2 period", p, PRE_P * (1 << (2 * r)));
    end
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h03);
    check("R4 rewrite", rate_q, 3);

    // R3 normal mode lock
    mode_special = 1'b0;
    do_reset();
    wr(1'b0, 8'h02);
    check("R3 first write", rate_q, 2);
    wr(1'b0, 8'h03);
    check("R3 second write ignored", rate_q, 2);
    do_reset();
    repeat (WIN_LEN + 4) @(negedge clk);
    wr(1'b0, 8'h01);
    check("R3 late write ignored", rate_q, 0);
    mode_special = 1'b1;
    wr(1'b0, 8'h01);
    check("R4 special after window", rate_q, 1);

    // R5 keyed service with intervening writes keeps timeout away
    n = 0;
    for (int k = 0; k < 20; k++) begin
      int c;
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h12);
      wr(1'b0, 8'h01);
      wr(1'b1, 8'hAA);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (timeout) n++;
      end
      c = k;
    end
    check("R5 serviced no timeout", n, 0);

    // R6 unarmed clears do not help
    wait_pulse(2000, n);
    p = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); wr_en = (i % 5 == 0); wr_sel = 1'b1; wr_data = 8'hAA;
      p++;
      if (timeout) break;
    end
    wr_en = 1'b0;
    check("R6 unarmed AA ignored", p, PRE_P * 4);

    // R9 prescaler not cleared by servicing
    wait_pulse(2000, n);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hAA);
    wait_pulse(2000, n);
    n = n + 1;
    check("R9 lower bound", int'(n > 3 * PRE_P), 1);
    check("R9 upper bound", int'(n <= 4 * PRE_P + 2), 1);

    // R7 disable and inhibit
    cfg_enable = 1'b0;
    count_pulses(600, n);
    check("R7 disabled", n, 0);
    cfg_enable = 1'b1; inhibit = 1'b1;
    count_pulses(600, n);
    check("R7 inhibited", n, 0);
    inhibit = 1'b0;
    period(p);
    check("R7 resumed period", p, PRE_P * 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule